// File: doc/BRIEF.md
# Banked Work RAM Controller

This block holds the general-purpose work memory of an 8-bit system. The bus sees two 4 KiB windows. The lower window at C000-CFFF always reaches the same fixed bank. The upper window at D000-DFFF reaches whichever of the numbered banks a select register names. The select register sits at the I/O address FF70. Addresses E000-FDFF mirror the work memory: the block folds them onto C000-DFFF before it decodes anything else.

A mode input chooses between the banked colour behaviour and a flat monochrome behaviour. In monochrome mode the upper window is pinned to bank 1. In that mode the select register no longer exists: a read of it returns FF and a write to it changes nothing. Requests are single bytes and take one cycle each. A read answers one cycle later from a synchronous RAM. Addresses the block does not own are ignored.

Top module: `wram_bank_ctrl`

## Requirements
- R1: During reset `rsp_valid_o` is low. After synchronous reset the bank select holds 1, so a colour-mode read of FF70 returns 8'h01.
- R2: A read the block owns (C000-FDFF, or FF70) raises `rsp_valid_o` with its data exactly one cycle after the request. A write never raises `rsp_valid_o`.
- R3: C000-CFFF always reaches the fixed bank (storage bank 0), whatever the bank select holds.
- R4: D000-DFFF reaches storage bank B at offset (address - D000), where B is the current bank select in colour mode.
- R5: In colour mode a write to FF70 stores the low BANK_SEL_W bits (3 by default) of the data. A stored value of 0 is replaced by 1, so the select is never 0.
- R6: In colour mode a read of FF70 returns the bank select zero-extended to 8 bits.
- R7: An address in E000-FDFF is turned into C000 + ((address - E000) & 1FFF) before decoding. E010 reaches C010, and FDFF reaches DDFF in the selected bank.
- R8: In monochrome mode (`color_mode_i` = 0) a read of FF70 returns 8'hFF. A write to FF70 leaves the bank select unchanged. D000-DFFF reaches storage bank 1.
- R9: A read outside C000-FDFF and FF70 gives no response. A write there changes no stored byte and no bank select.
- R10: Each bank stores 2^BANK_AW bytes (default BANK_AW = 8). Only the low BANK_AW bits of the window offset select a byte, so C105 reaches the same byte as C005 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| color_mode_i | input | 1 | 1 = banked colour mode, 0 = flat monochrome mode |
| req_i | input | 1 | Byte request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid (one cycle after the read) |
| rsp_data_o | output | 8 | Read data |

## Verification
The bench writes the same window offset under different bank selects and reads each one back, which catches a design that ignores the select or lets it leak into the fixed lower window. Bank-select writes of 0 and of values with high bits set catch a select that can become 0 or keeps the wrong bits. The mirror is checked at both ends, including FDFF landing in the banked upper window, which catches a fold that uses the wrong base or mask. Monochrome FF70 accesses and unowned addresses are checked for their read values, their silence, and the unchanged select seen once colour mode returns; a design that kept the register alive in monochrome mode, or answered foreign addresses, shows there.

// File: rtl/wram_pkg.sv
// Package: shared address map, region type and mirror folding for the
// banked work RAM controller. Assumes a 16-bit byte address bus.
package wram_pkg;

    localparam logic [15:0] LOWER_BASE    = 16'hC000;
    localparam logic [15:0] LOWER_LAST    = 16'hCFFF;
    localparam logic [15:0] UPPER_BASE    = 16'hD000;
    localparam logic [15:0] UPPER_LAST    = 16'hDFFF;
    localparam logic [15:0] MIRROR_BASE   = 16'hE000;
    localparam logic [15:0] MIRROR_LAST   = 16'hFDFF;
    localparam logic [15:0] MIRROR_MASK   = 16'h1FFF;
    localparam logic [15:0] BANK_SEL_ADDR = 16'hFF70;
    localparam logic [7:0]  MONO_SEL_READ = 8'hFF;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_LOWER  = 2'd1,
        RGN_UPPER  = 2'd2,
        RGN_SELECT = 2'd3
    } region_e;

    // Map a mirror address onto the work RAM range; other addresses pass through.
    function automatic logic [15:0] fold_mirror(input logic [15:0] a);
        if (a >= MIRROR_BASE && a <= MIRROR_LAST)
            return LOWER_BASE + ((a - MIRROR_BASE) & MIRROR_MASK);
        return a;
    endfunction

endpackage

// File: rtl/wram_addr_decode.sv
// Module: wram_addr_decode
// Folds mirror addresses, sorts the address into a region and builds the
// storage index. Purely combinational. Assumes BANK_AW <= 12 (the window
// is 4 KiB) and that the caller qualifies the outputs with its request strobe.
module wram_addr_decode
    import wram_pkg::*;
#(
    parameter int BANK_AW    = 8,
    parameter int BANK_SEL_W = 3
) (
    input  logic [15:0]                   addr_i,
    input  logic                          color_i,
    input  logic [BANK_SEL_W-1:0]         bank_i,
    output region_e                       region_o,
    output logic [BANK_SEL_W+BANK_AW-1:0] idx_o
);

    logic [15:0]           folded;
    logic [BANK_SEL_W-1:0] eff_bank;
    logic [BANK_AW-1:0]    offset;

    // Mirror folding comes before every other decode step.
    assign folded   = fold_mirror(addr_i);
    // Monochrome mode pins the upper window to bank 1.
    assign eff_bank = color_i ? bank_i : BANK_SEL_W'(1);
    assign offset   = folded[BANK_AW-1:0];

    // Region classification and storage index generation.
    always_comb begin
        region_o = RGN_NONE;
        idx_o    = '0;
        if (folded >= LOWER_BASE && folded <= LOWER_LAST) begin
            region_o = RGN_LOWER;
            idx_o    = {{BANK_SEL_W{1'b0}}, offset};
        end else if (folded >= UPPER_BASE && folded <= UPPER_LAST) begin
            region_o = RGN_UPPER;
            idx_o    = {eff_bank, offset};
        end else if (folded == BANK_SEL_ADDR) begin
            region_o = RGN_SELECT;
        end
    end

endmodule

// File: rtl/wram_bank_reg.sv
// Module: wram_bank_reg
// Holds the upper-window bank select. Resets to 1 and replaces a written 0
// with 1. Assumes the caller gates wr_en_i with colour mode.
module wram_bank_reg #(
    parameter int BANK_SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [BANK_SEL_W-1:0] wdata_i,
    output logic [BANK_SEL_W-1:0] bank_o
);

    logic [BANK_SEL_W-1:0] bank_d;

    // Substitute bank 1 for a zero request.
    assign bank_d = (wdata_i == '0) ? BANK_SEL_W'(1) : wdata_i;

    // Bank select register with synchronous reset to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_o <= BANK_SEL_W'(1);
        else if (wr_en_i)
            bank_o <= bank_d;
    end

    // R5: a write lands the low bits, zero becoming one
    a_r5_bank_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> bank_o == (($past(wdata_i) == '0) ? BANK_SEL_W'(1) : $past(wdata_i)));

    // R5: no write, no change
    a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_o));

    // R5: the select never reads as zero
    a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o != '0);

endmodule

// File: rtl/wram_storage.sv
// Module: wram_storage
// Single-port synchronous byte RAM with one cycle of read latency. Holds
// its old read data during writes. Assumes no reset of contents.
module wram_storage #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    // Write or registered read on an enabled cycle.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i)
                mem[idx_i] <= wdata_i;
            else
                rdata_o <= mem[idx_i];
        end
    end

endmodule

// File: rtl/wram_bank_ctrl.sv
// Module: wram_bank_ctrl (top)
// Banked work RAM: fixed lower window, bank-selected upper window, mirror
// folding and an FF70 bank select that vanishes in monochrome mode. Reads
// answer one cycle later. Assumes one byte request per cycle and that
// addresses outside its map belong to other blocks.
module wram_bank_ctrl
    import wram_pkg::*;
#(
    parameter int BANK_AW    = 8,
    parameter int BANK_SEL_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        color_mode_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [15:0] addr_i,
    input  logic [7:0]  wdata_i,
    output logic        rsp_valid_o,
    output logic [7:0]  rsp_data_o
);

    localparam int IDX_W = BANK_SEL_W + BANK_AW;

    region_e               region;
    logic [IDX_W-1:0]      idx;
    logic [BANK_SEL_W-1:0] bank_q;
    logic [7:0]            ram_rdata;
    logic                  ram_en;
    logic                  sel_wr;
    logic                  rd_hit;
    logic                  sel_rd;
    logic                  sel_rd_q;
    logic [7:0]            sel_data_q;
    logic                  rsp_valid_q;

    wram_addr_decode #(
        .BANK_AW   (BANK_AW),
        .BANK_SEL_W(BANK_SEL_W)
    ) decode_i (
        .addr_i  (addr_i),
        .color_i (color_mode_i),
        .bank_i  (bank_q),
        .region_o(region),
        .idx_o   (idx)
    );

    wram_bank_reg #(
        .BANK_SEL_W(BANK_SEL_W)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(sel_wr),
        .wdata_i(wdata_i[BANK_SEL_W-1:0]),
        .bank_o (bank_q)
    );

    wram_storage #(
        .IDX_W(IDX_W)
    ) store_i (
        .clk    (clk),
        .en_i   (ram_en),
        .we_i   (we_i),
        .idx_i  (idx),
        .wdata_i(wdata_i),
        .rdata_o(ram_rdata)
    );

    // Request qualification per region.
    assign ram_en = req_i && (region == RGN_LOWER || region == RGN_UPPER);
    assign sel_wr = req_i && we_i && (region == RGN_SELECT) && color_mode_i;
    assign rd_hit = req_i && !we_i && (region != RGN_NONE);
    assign sel_rd = req_i && !we_i && (region == RGN_SELECT);

    // Response pipeline: valid flag and select-register read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            sel_rd_q    <= 1'b0;
            sel_data_q  <= '0;
        end else begin
            rsp_valid_q <= rd_hit;
            sel_rd_q    <= sel_rd;
            sel_data_q  <= color_mode_i ? 8'(bank_q) : MONO_SEL_READ;
        end
    end

    // Output steering between RAM and select register.
    assign rsp_valid_o = rsp_valid_q;
    assign rsp_data_o  = sel_rd_q ? sel_data_q : ram_rdata;

    // R2: writes stay silent
    a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i) |=> !rsp_valid_o);

    // R2: an owned read is answered next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && ((addr_i >= LOWER_BASE && addr_i <= MIRROR_LAST) || addr_i == BANK_SEL_ADDR))
        |=> rsp_valid_o);

    // R9: foreign addresses are never answered
    a_r9_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(addr_i >= LOWER_BASE && addr_i <= MIRROR_LAST) && addr_i != BANK_SEL_ADDR)
        |=> !rsp_valid_o);

    // R6: colour-mode select read returns the bank
    a_r6_select_reads_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == BANK_SEL_ADDR && color_mode_i)
        |=> rsp_data_o == 8'($past(bank_q)));

    // R8: monochrome select read returns FF
    a_r8_mono_select_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == BANK_SEL_ADDR && !color_mode_i)
        |=> rsp_data_o == 8'hFF);

    // R8: monochrome select write leaves the bank alone
    a_r8_mono_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i == BANK_SEL_ADDR && !color_mode_i)
        |=> $stable(bank_q));

endmodule

// File: tb/wram_bank_ctrl_tb_top.sv
// Bench: a driver task queues expected responses (or expected silence) per
// request, and a monitor compares them in the cycle they fall due.
module wram_bank_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LP_AW      = 8;
    localparam int LP_SW      = 3;

    typedef struct {
        logic        v;
        logic [7:0]  d;
        int          due;
        logic [15:0] a;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        color_mode = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    logic mon_en = 1'b0;
    exp_t exp_q[$];
    exp_t mon_item;

    logic [7:0]       m_mem [1 << (LP_SW + LP_AW)];
    logic [LP_SW-1:0] m_bank = 1;
    logic             m_color = 1'b1;

    wram_bank_ctrl #(.BANK_AW(LP_AW), .BANK_SEL_W(LP_SW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .color_mode_i(color_mode),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Model index from the requirements (R3, R4, R7, R8, R10).
    function automatic int model_idx(input logic [15:0] f);
        logic [LP_SW-1:0] b;
        b = m_color ? m_bank : LP_SW'(1);
        if (f <= 16'hCFFF) return int'(f[LP_AW-1:0]);
        return (int'(b) << LP_AW) + int'(f[LP_AW-1:0]);
    endfunction

    // Driver: issue one request and queue what must come back.
    task automatic op(input logic w, input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t it;
        logic [15:0] f;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        f = a;
        if (a >= 16'hE000 && a <= 16'hFDFF) f = 16'hC000 + ((a - 16'hE000) & 16'h1FFF);
        it.v = 1'b0; it.d = '0; it.due = cyc + 1; it.a = a; it.tag = tag;
        if (f >= 16'hC000 && f <= 16'hDFFF) begin
            if (w) m_mem[model_idx(f)] = d;
            else begin it.v = 1'b1; it.d = m_mem[model_idx(f)]; end
        end else if (a == 16'hFF70) begin
            if (w) begin
                if (m_color) m_bank = (d[LP_SW-1:0] == '0) ? LP_SW'(1) : d[LP_SW-1:0];
            end else begin
                it.v = 1'b1;
                it.d = m_color ? 8'(m_bank) : 8'hFF;
            end
        end
        exp_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic set_mode(input logic c);
        @(negedge clk);
        req = 1'b0;
        color_mode = c;
        m_color = c;
    endtask

    // Monitor: compare due items; flag any response nobody asked for.
    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                mon_item = exp_q.pop_front();
                n_checks++;
                if (mon_item.v) begin
                    if (rsp_valid !== 1'b1 || rsp_data !== mon_item.d) begin
                        n_errors++;
                        $display("FAIL %s addr=%h: got valid=%b data=%h, expected valid=1 data=%h",
                                 mon_item.tag, mon_item.a, rsp_valid, rsp_data, mon_item.d);
                    end
                end else if (rsp_valid !== 1'b0) begin
                    n_errors++;
                    $display("FAIL %s addr=%h: got valid=%b, expected valid=0",
                             mon_item.tag, mon_item.a, rsp_valid);
                end
            end else if (rsp_valid !== 1'b0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R2 unrequested response: got valid=%b, expected valid=0", rsp_valid);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 valid in reset: got %b, expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        mon_en = 1'b1;

        op(1'b0, 16'hFF70, 8'h00, "R1");          // reset bank is 1
        op(1'b1, 16'hC000, 8'h11, "R3");
        op(1'b1, 16'hD000, 8'h22, "R4");          // bank 1
        op(1'b1, 16'hFF70, 8'h03, "R5");
        op(1'b1, 16'hD000, 8'h33, "R4");          // bank 3
        op(1'b0, 16'hD000, 8'h00, "R4");          // expect 33
        op(1'b1, 16'hFF70, 8'h01, "R5");
        op(1'b0, 16'hD000, 8'h00, "R4");          // expect 22
        op(1'b0, 16'hC000, 8'h00, "R3");
        op(1'b1, 16'hFF70, 8'h03, "R5");
        op(1'b0, 16'hC000, 8'h00, "R3");          // lower fixed under bank 3
        op(1'b1, 16'hFF70, 8'h00, "R5");          // zero becomes one
        op(1'b0, 16'hFF70, 8'h00, "R5");
        op(1'b1, 16'hFF70, 8'hFD, "R5");          // low bits 5
        op(1'b0, 16'hFF70, 8'h00, "R6");
        op(1'b1, 16'hE010, 8'h5A, "R7");
        op(1'b0, 16'hC010, 8'h00, "R7");
        op(1'b1, 16'hF123, 8'h6B, "R7");
        op(1'b0, 16'hD123, 8'h00, "R7");
        op(1'b1, 16'hDDFF, 8'h7C, "R7");
        op(1'b0, 16'hFDFF, 8'h00, "R7");
        op(1'b1, 16'hC005, 8'h9E, "R10");
        op(1'b0, 16'hC105, 8'h00, "R10");         // aliases C005
        op(1'b1, 16'h8000, 8'hAA, "R9");
        op(1'b1, 16'hFF71, 8'h07, "R9");
        op(1'b0, 16'h8000, 8'h00, "R9");
        op(1'b0, 16'hFE00, 8'h00, "R9");
        op(1'b0, 16'hC000, 8'h00, "R9");          // untouched by foreign writes
        op(1'b0, 16'hFF70, 8'h00, "R9");          // still bank 5
        idle();

        set_mode(1'b0);
        op(1'b0, 16'hFF70, 8'h00, "R8");          // FF in monochrome
        op(1'b1, 16'hFF70, 8'h02, "R8");          // ignored
        op(1'b1, 16'hD010, 8'h44, "R8");          // goes to bank 1
        op(1'b0, 16'hD010, 8'h00, "R8");
        idle();
        set_mode(1'b1);
        op(1'b0, 16'hFF70, 8'h00, "R8");          // still 5
        op(1'b1, 16'hFF70, 8'h01, "R5");
        op(1'b0, 16'hD010, 8'h00, "R8");          // bank 1 holds 44
        op(1'b0, 16'hD000, 8'h00, "R4");          // bank 1 holds 22
        idle();

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R2 pending responses: got %0d left, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule